// File: doc/BRIEF.md
# Strobed Parallel Port Interface

This block connects a processor register bus to an 8-bit external device. It has one receive channel and one transmit channel. In the receive channel, a device strobe captures the device data into a holding register. A flag then shows that the register holds unread data. In the transmit channel, a processor write puts a byte on the device pins. The block then pulses a strobe so the device can take the byte. A flag shows when the transmit register can accept the next byte.

Software can use the channels in two ways. It can poll the two flags through the status register. It can also enable a level interrupt for each channel and wait for it. The block answers the bus only while its select input is high. The bus is a plain synchronous interface with separate read and write enables.

Both device-side paths are plain strobed transfers and have no back-pressure. On the receive side, a new byte always replaces the held one, and the block records this as an overrun. On the transmit side, a write that arrives while a transfer is still running is dropped. Software avoids this by waiting for the empty flag.

Top module: `strobed_pport`

## Requirements
- R1: After reset, the status register reads 0x02 (nothing received, transmit empty, no overrun), the interrupt-enable register reads 0, and `dev_out`, `dev_stb_out`, `irq_in` and `irq_out` are all 0.
- R2: A rising edge on `dev_stb_in` captures `dev_in` and sets the receive-valid flag. The strobe passes through two synchronizer flops and an edge detector, so the captured byte and the flag appear exactly 3 clocks after the strobe rises.
- R3: A selected read of offset 0 returns the received byte on `rdata` in the same cycle and clears the receive-valid flag.
- R4: A strobe edge that arrives while the valid flag is set replaces the held byte and sets the overrun flag. That flag stays set until a status write (offset 1) with bit 2 = 1 clears it.
- R5: A selected write to offset 0 while the transmit register is empty puts `wdata` on `dev_out` at the next clock edge and clears the empty flag.
- R6: `dev_stb_out` rises one clock after `dev_out` takes the new byte and stays high for exactly 2 clocks, with `dev_out` held steady. The empty flag is set again on the clock where the strobe falls.
- R7: A write to offset 0 while the transmit empty flag is clear is ignored: `dev_out` and the strobe timing do not change.
- R8: Offset 2 holds the interrupt enables: bit 0 for receive, bit 1 for transmit, and it reads back as written. `irq_in` equals valid AND bit 0. `irq_out` equals empty AND bit 1.
- R9: While `sel` is low, `rdata` is 0, writes have no effect, and reads do not clear the valid flag.
- R10: The status register at offset 1 reads receive-valid in bit 0, transmit-empty in bit 1 and overrun in bit 2. Bits 7..3 read 0.
- R11: A strobe held high for many clocks captures only once. A change on `dev_in` after the capture is not taken in, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Address-decode select; enables bus response |
| rd_en | input | 1 | Bus read enable |
| wr_en | input | 1 | Bus write enable |
| addr | input | 2 | Register offset (0 data, 1 status, 2 interrupt enable) |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational, 0 when not reading |
| dev_in | input | 8 | Device data into the receive channel |
| dev_stb_in | input | 1 | Device strobe, asynchronous, rising edge captures |
| dev_out | output | 8 | Data driven to the device |
| dev_stb_out | output | 1 | Strobe to the device, 2 clocks wide |
| irq_in | output | 1 | Receive interrupt request (level) |
| irq_out | output | 1 | Transmit interrupt request (level) |

## Verification
The receive path is tested in several ways: a short strobe pulse, a strobe held high while the data changes, two strobes with no read between them, and a strobe while the bus is deselected. Each case gives a different result: a single capture, a missed late byte, an overrun, or a flag that a deselected read must not clear. The transmit path is tested with an isolated write and with a second write that lands during the setup cycle. The exact strobe cycles show whether the data is set up first and whether the busy write is dropped. A random mix of strobes, reads, writes and overrun clears then follows a model of the valid, overrun and data state, to catch wrong interactions between the flags.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] OFS_DATA = 2'd0;
  localparam logic [AW-1:0] OFS_STAT = 2'd1;
  localparam logic [AW-1:0] OFS_IEN  = 2'd2;

  localparam int unsigned ST_VALID = 0;
  localparam int unsigned ST_EMPTY = 1;
  localparam int unsigned ST_OVR   = 2;

  localparam int unsigned IE_IN  = 0;
  localparam int unsigned IE_OUT = 1;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SETUP = 2'd1,
    TX_STB   = 2'd2
  } tx_state_e;
endpackage

// File: rtl/pport_rx_chan.sv
module pport_rx_chan #(
  parameter int unsigned W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dev_in,
  input  logic         dev_stb,
  input  logic         rd_take,
  input  logic         ovr_clr,
  output logic [W-1:0] data,
  output logic         valid,
  output logic         overrun
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   edge_seen;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= dev_stb;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], dev_stb};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign edge_seen = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data    <= '0;
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (edge_seen) data <= dev_in;
      if (edge_seen)    valid <= 1'b1;
      else if (rd_take) valid <= 1'b0;
      if (edge_seen && valid && !rd_take) overrun <= 1'b1;
      else if (ovr_clr)                   overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/pport_tx_chan.sv
module pport_tx_chan
  import pport_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned STB_CYC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_take,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dev_out,
  output logic         dev_stb,
  output logic         empty
);
  localparam int unsigned MAXC = (SETUP_CYC > STB_CYC) ? SETUP_CYC : STB_CYC;
  localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  tx_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      out_q   <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (wr_take) begin
            out_q   <= wdata;
            state_q <= TX_SETUP;
            cnt_q   <= CW'(SETUP_CYC - 1);
          end
        end
        TX_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= TX_STB;
            cnt_q   <= CW'(STB_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        TX_STB: begin
          if (cnt_q == '0) state_q <= TX_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign dev_out = out_q;
  assign dev_stb = (state_q == TX_STB);
  assign empty   = (state_q == TX_IDLE);
endmodule

// File: rtl/pport_bus.sv
module pport_bus
  import pport_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    ctl_bits,
  input  logic [W-1:0]  rx_data,
  input  logic          rx_valid,
  input  logic          rx_ovr,
  input  logic          tx_empty,
  output logic [W-1:0]  rdata,
  output logic          rd_take,
  output logic          wr_take,
  output logic          ovr_clr,
  output logic [1:0]    ien
);
  logic rd_hit, wr_hit;

  assign rd_hit  = sel & rd_en;
  assign wr_hit  = sel & wr_en;
  assign rd_take = rd_hit & (addr == OFS_DATA);
  assign wr_take = wr_hit & (addr == OFS_DATA);
  assign ovr_clr = wr_hit & (addr == OFS_STAT) & ctl_bits[ST_OVR];

  always_ff @(posedge clk) begin
    if (!rst_n)                         ien <= 2'b00;
    else if (wr_hit && addr == OFS_IEN) ien <= ctl_bits[1:0];
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      unique case (addr)
        OFS_DATA: rdata = rx_data;
        OFS_STAT: begin
          rdata[ST_VALID] = rx_valid;
          rdata[ST_EMPTY] = tx_empty;
          rdata[ST_OVR]   = rx_ovr;
        end
        OFS_IEN:  rdata[1:0] = ien;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/strobed_pport.sv
module strobed_pport
  import pport_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned STB_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  dev_in,
  input  logic          dev_stb_in,
  output logic [W-1:0]  dev_out,
  output logic          dev_stb_out,
  output logic          irq_in,
  output logic          irq_out
);
  logic [W-1:0] rx_data;
  logic         in_valid, rx_ovr, out_empty;
  logic         rd_take, wr_take, ovr_clr;
  logic [1:0]   ien;

  pport_rx_chan #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .dev_in(dev_in), .dev_stb(dev_stb_in),
    .rd_take(rd_take), .ovr_clr(ovr_clr),
    .data(rx_data), .valid(in_valid), .overrun(rx_ovr)
  );

  pport_tx_chan #(.W(W), .SETUP_CYC(SETUP_CYC), .STB_CYC(STB_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_take(wr_take), .wdata(wdata),
    .dev_out(dev_out), .dev_stb(dev_stb_out), .empty(out_empty)
  );

  pport_bus #(.W(W)) u_bus (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .ctl_bits(wdata[2:0]), .rx_data(rx_data),
    .rx_valid(in_valid), .rx_ovr(rx_ovr), .tx_empty(out_empty),
    .rdata(rdata), .rd_take(rd_take), .wr_take(wr_take),
    .ovr_clr(ovr_clr), .ien(ien)
  );

  assign irq_in  = in_valid  & ien[IE_IN];
  assign irq_out = out_empty & ien[IE_OUT];
endmodule

// File: rtl/pport_chk.sv
module pport_chk #(
  parameter int unsigned W = 8,
  parameter int unsigned STB_CYC = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [W-1:0] dev_out,
  input logic         dev_stb_out,
  input logic         irq_in,
  input logic         irq_out,
  input logic         in_valid,
  input logic         out_empty
);
  localparam int unsigned RW = $clog2(STB_CYC + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           run_q <= '0;
    else if (dev_stb_out) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  // R9
  unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> rdata == '0);
  // R8
  irq_in_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |-> in_valid);
  // R8
  irq_out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> out_empty);
  // R6
  stb_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_stb_out |-> $stable(dev_out));
  // R6
  stb_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_stb_out |-> !out_empty);
  // R6
  stb_max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_stb_out |-> run_q < RW'(STB_CYC));
  // R6
  stb_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_stb_out && run_q != '0) |-> run_q == RW'(STB_CYC));
  // R5
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr == 2'd0 && out_empty) |=>
      (!out_empty && dev_out == $past(wdata)));
  // R7
  tx_busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr == 2'd0 && !out_empty) |=> $stable(dev_out));
endmodule

bind strobed_pport pport_chk #(.W(W), .STB_CYC(STB_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .dev_out(dev_out), .dev_stb_out(dev_stb_out),
  .irq_in(irq_in), .irq_out(irq_out), .in_valid(in_valid), .out_empty(out_empty)
);

// File: tb/test_strobed_pport.sv
module test_strobed_pport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] dev_in = 8'h00;
  logic       dev_stb_in = 1'b0;
  logic [7:0] dev_out;
  logic       dev_stb_out, irq_in, irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit       m_valid = 1'b0, m_ovr = 1'b0;
  logic [7:0] m_data = 8'h00;

  always #2 clk = ~clk;

  strobed_pport i_strobed_pport (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .dev_in(dev_in),
    .dev_stb_in(dev_stb_in), .dev_out(dev_out), .dev_stb_out(dev_stb_out),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  function automatic logic [7:0] exp_status(bit v, bit e, bit o);
    return {5'b00000, o, e, v};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    sel = 1'b1; rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; rd_en = 1'b0;
    if (a == 2'd0) m_valid = 1'b0;
  endtask

  task automatic pulse_in(input logic [7:0] d, input int hold);
    dev_in = d; dev_stb_in = 1'b1;
    repeat (hold) @(negedge clk);
    dev_stb_in = 1'b0;
    repeat (3) @(negedge clk);
    if (m_valid) m_ovr = 1'b1;
    m_valid = 1'b1; m_data = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 dev_out", dev_out, 8'h00);
    check("R1 dev_stb_out", dev_stb_out, 1'b0);
    check("R1 irqs", {irq_in, irq_out}, 2'b00);
    bus_rd(2'd1, r); check("R1 status", r, 8'h02);
    bus_rd(2'd2, r); check("R1 ien", r, 8'h00);

    // R8 enables
    bus_wr(2'd2, 8'hFF);
    bus_rd(2'd2, r); check("R8 ien readback", r, 8'h03);
    check("R8 irq_out when empty", irq_out, 1'b1);
    check("R8 irq_in when no data", irq_in, 1'b0);

    // R2 latency of capture
    dev_in = 8'hA5; dev_stb_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 not yet valid after 2 clocks", irq_in, 1'b0);
    @(negedge clk);
    check("R2 valid after 3 clocks", irq_in, 1'b1);
    dev_stb_in = 1'b0;
    repeat (3) @(negedge clk);
    m_valid = 1'b1; m_data = 8'hA5;
    // R10 status layout
    bus_rd(2'd1, r); check("R10 status valid+empty", r, 8'h03);

    // R3 read clears
    bus_rd(2'd0, r); check("R3 data", r, 8'hA5);
    bus_rd(2'd1, r); check("R3 valid cleared", r, 8'h02);
    check("R3 irq_in low", irq_in, 1'b0);

    // R11 held strobe captures once
    dev_in = 8'h11; dev_stb_in = 1'b1;
    repeat (3) @(negedge clk);
    dev_in = 8'h22;
    repeat (6) @(negedge clk);
    dev_stb_in = 1'b0;
    repeat (3) @(negedge clk);
    m_valid = 1'b1; m_data = 8'h11;
    bus_rd(2'd1, r); check("R11 no overrun on held strobe", r, 8'h03);
    bus_rd(2'd0, r); check("R11 first byte kept", r, 8'h11);

    // R4 overrun
    pulse_in(8'h33, 1);
    pulse_in(8'h44, 2);
    bus_rd(2'd1, r); check("R4 overrun status", r, 8'h07);
    bus_rd(2'd0, r); check("R4 newest byte", r, 8'h44);
    bus_rd(2'd1, r); check("R4 overrun sticky", r, 8'h06);
    bus_wr(2'd1, 8'h04); m_ovr = 1'b0;
    bus_rd(2'd1, r); check("R4 overrun cleared", r, 8'h02);

    // R5/R6 transmit
    bus_wr(2'd0, 8'h5A);
    check("R5 dev_out loaded", dev_out, 8'h5A);
    check("R5 empty cleared", irq_out, 1'b0);
    check("R6 strobe not yet", dev_stb_out, 1'b0);
    @(negedge clk); check("R6 strobe cycle 1", dev_stb_out, 1'b1);
    @(negedge clk); check("R6 strobe cycle 2", dev_stb_out, 1'b1);
    check("R6 data held", dev_out, 8'h5A);
    check("R6 still busy", irq_out, 1'b0);
    @(negedge clk); check("R6 strobe ended", dev_stb_out, 1'b0);
    check("R6 empty set at strobe end", irq_out, 1'b1);

    // R7 write during setup dropped
    bus_wr(2'd0, 8'hC3);
    bus_wr(2'd0, 8'h99);
    check("R7 busy write dropped", dev_out, 8'hC3);
    check("R7 strobe timing kept", dev_stb_out, 1'b1);
    @(negedge clk); check("R7 strobe second cycle", dev_stb_out, 1'b1);
    @(negedge clk); check("R7 strobe end", dev_stb_out, 1'b0);
    check("R7 dev_out unchanged", dev_out, 8'hC3);

    // R9 unselected access
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h77;
    @(negedge clk); wr_en = 1'b0;
    check("R9 unselected write", dev_out, 8'hC3);
    @(negedge clk); check("R9 no strobe", dev_stb_out, 1'b0);
    pulse_in(8'h6C, 1);
    rd_en = 1'b1; addr = 2'd0;
    #1 check("R9 rdata zero", rdata, 8'h00);
    @(negedge clk); rd_en = 1'b0;
    bus_rd(2'd1, r); check("R9 unselected read kept valid", r, 8'h03);
    bus_rd(2'd0, r); check("R9 byte intact", r, 8'h6C);

    // Random phase
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 4);
      d  = 8'($urandom);
      case (op)
        0: pulse_in(d, 1 + int'($urandom % 4));
        1: begin
          logic [7:0] exp_d;
          exp_d = m_data;
          bus_rd(2'd0, r); check("R3 random data", r, exp_d);
        end
        2: begin
          bus_wr(2'd0, d);
          check("R5 random load", dev_out, d);
          repeat (3) @(negedge clk);
          check("R6 random done", {dev_stb_out, irq_out}, 2'b01);
        end
        default: begin
          bus_rd(2'd1, r);
          check("R10 random status", r, exp_status(m_valid, 1'b1, m_ovr));
          check("R8 random irq_in", irq_in, m_valid);
          if ($urandom % 2 == 0) begin
            bus_wr(2'd1, 8'h04); m_ovr = 1'b0;
          end
        end
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule